// File: doc/BRIEF.md
# Packet Buffer with Store-and-Forward or Cut-Through Release

This block is a single-clock packet buffer. Beats enter on a write side made of data, an end-of-packet marker, and a valid/ready handshake. They leave in the same order on a read side with the same signals. A build-time mode picks when the head packet may start leaving the buffer.

- **Store-and-forward mode:** the head packet is offered only once its final beat has been stored. A counter of complete packets gates the release.
- **Cut-through mode:** the head packet is offered as soon as occupancy reaches a start level, or as soon as a complete packet is held, whichever comes first. A short packet is therefore not held back.

Two occupancy thresholds drive sticky flags in a two-bit status word. Software-style logic reads the word directly. It clears bits by pulsing a clear strobe together with a mask, where a 1 in the mask clears that bit.

The release logic is a two-state machine:

| State | Meaning | Read side |
|---|---|---|
| `REL_IDLE` | Between packets | Output is offered only while the release gate is open and the buffer is not empty |
| `REL_SEND` | A packet has started leaving | Output is offered whenever the buffer is not empty |

Its two transitions are:

- **`T_START`** (`REL_IDLE` to `REL_SEND`): a beat that is not the last of its packet is read.
- **`T_FINISH`** (`REL_SEND` to `REL_IDLE`): the last beat of a packet is read.

A single-beat packet read in `REL_IDLE` leaves the state unchanged.

Top module: `pkt_fifo`

## Requirements
- R1: `in_ready` is low exactly while DEPTH entries are held. A beat offered while `in_ready` is low is discarded and never appears at the output.
- R2: Beats leave in the order they were written, each with the data and end-of-packet marker it was written with.
- R3: In store-and-forward mode (CUT_THROUGH=0), `out_valid` stays low while no complete packet is held. It is high in the cycle after the edge that stores a packet's last beat.
- R4: In store-and-forward mode, once a packet has started leaving, `out_valid` stays high until its last beat has been read.
- R5: In cut-through mode (CUT_THROUGH=1), `out_valid` is high in the cycle after occupancy reaches START_LEVEL, even when no last beat has been stored.
- R6: In cut-through mode, a packet whose last beat is stored while occupancy is below START_LEVEL is offered in the cycle after that edge.
- R7: A write and a read accepted at the same edge leave occupancy unchanged.
- R8: Status bit 0 (programmable full) is set at every edge where occupancy, before the edge, is at least PF_LEVEL (default 507). Once set, it stays set until it is cleared.
- R9: Status bit 1 (programmable empty) is set at every edge where occupancy, before the edge, is at most PE_LEVEL (default 5). Once set, it stays set until it is cleared. It therefore sets at the first edge after reset.
- R10: At an edge where `stat_clr` is high, each status bit whose `stat_clr_mask` bit is 1 becomes 0. It is set again at the following edge if its condition still holds. Bits whose mask bit is 0 are unaffected by the clear.
- R11: While `rst_n` is low, `out_valid` is low, `in_ready` is high and both status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Write beat offered |
| in_ready | output | 1 | Buffer can accept a beat |
| in_data | input | DATA_W | Write beat data |
| in_last | input | 1 | Write beat ends its packet |
| out_valid | output | 1 | Read beat offered |
| out_ready | input | 1 | Reader takes the beat |
| out_data | output | DATA_W | Read beat data |
| out_last | output | 1 | Read beat ends its packet |
| stat_clr | input | 1 | Clear strobe for the status word |
| stat_clr_mask | input | 2 | Bits to clear: bit 0 full flag, bit 1 empty flag |
| stat_flags | output | 2 | Sticky status: bit 0 programmable full, bit 1 programmable empty |

## Verification
The bench runs two instances side by side on the same write stream, one in each release mode.

- **Long packet:** a 511-beat packet is written and its release is checked at every beat. This separates waiting for the last beat from starting at the level.
- **Mid-size packet:** a five-beat packet shows cut-through starting at the fourth beat while store-and-forward still waits.
- **Short packet:** a two-beat packet shows cut-through release on the last beat when occupancy is below the start level.
- **Full buffer and concurrent access:** filling to the limit, and then one beat beyond it, exercises the full flag, the discarding of refused beats and the simultaneous read-and-write case.

An arithmetic model of occupancy tracks every clock. The status word is compared with this model at every cycle, so each threshold crossing and each clear is checked against the cycle in which it should take effect.

// File: rtl/pktf_pkg.sv
package pktf_pkg;

    typedef enum logic {
        REL_IDLE = 1'b0,
        REL_SEND = 1'b1
    } rel_state_e;

    localparam int FLAG_PFULL  = 0;
    localparam int FLAG_PEMPTY = 1;
    localparam int FLAG_COUNT  = 2;

endpackage

// File: rtl/pktf_store.sv
module pktf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 512,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic [CW-1:0]     occupancy,
    output logic              full,
    output logic              empty
);

    logic [DATA_W:0] mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CW-1:0]   occ_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= {wr_last, wr_data};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ_q  <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (rd_en) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({wr_en, rd_en})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    always_comb begin
        rd_data   = mem[rd_ptr][DATA_W-1:0];
        rd_last   = mem[rd_ptr][DATA_W];
        occupancy = occ_q;
        full      = (occ_q == CW'(DEPTH));
        empty     = (occ_q == '0);
    end

    // R1: occupancy never exceeds the depth
    a_r1_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CW'(DEPTH));

    // R7: simultaneous write and read keep occupancy steady
    a_r7_balanced: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |=> (occupancy == $past(occupancy)));

endmodule

// File: rtl/pktf_release.sv
module pktf_release
    import pktf_pkg::*;
#(
    parameter int CUT_THROUGH = 0,
    parameter int START_LEVEL = 16,
    parameter int CW          = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] occupancy,
    input  logic          empty,
    input  logic          wr_last_fire,
    input  logic          rd_fire,
    input  logic          rd_last,
    output logic          out_valid
);

    rel_state_e    state_q;
    rel_state_e    state_d;
    logic [CW-1:0] pkt_cnt;
    logic          rd_last_fire;
    logic          gate;

    assign rd_last_fire = rd_fire && rd_last;

    // complete packets held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_cnt <= '0;
        end else begin
            unique case ({wr_last_fire, rd_last_fire})
                2'b10:   pkt_cnt <= pkt_cnt + 1'b1;
                2'b01:   pkt_cnt <= pkt_cnt - 1'b1;
                default: pkt_cnt <= pkt_cnt;
            endcase
        end
    end

    generate
        if (CUT_THROUGH != 0) begin : g_cut
            assign gate = (pkt_cnt != '0) || (occupancy >= CW'(START_LEVEL));
        end else begin : g_saf
            assign gate = (pkt_cnt != '0);
        end
    endgenerate

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= REL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REL_IDLE: if (rd_fire && !rd_last) state_d = REL_SEND;   // T_START
            REL_SEND: if (rd_last_fire)        state_d = REL_IDLE;   // T_FINISH
            default:  state_d = REL_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        unique case (state_q)
            REL_IDLE: out_valid = gate && !empty;
            REL_SEND: out_valid = !empty;
            default:  out_valid = 1'b0;
        endcase
    end

    // R3: store-and-forward offers data only while a complete packet is held
    a_r3_saf_complete: assert property (@(posedge clk) disable iff (!rst_n)
        (CUT_THROUGH == 0 && out_valid) |-> (pkt_cnt != '0));

    // R4: store-and-forward never runs dry inside a packet
    a_r4_saf_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (CUT_THROUGH == 0 && state_q == REL_SEND) |-> !empty);

endmodule

// File: rtl/pktf_flags.sv
module pktf_flags
    import pktf_pkg::*;
#(
    parameter int CW       = 10,
    parameter int PF_LEVEL = 507,
    parameter int PE_LEVEL = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CW-1:0]         occupancy,
    input  logic                  clr,
    input  logic [FLAG_COUNT-1:0] clr_mask,
    output logic [FLAG_COUNT-1:0] flags
);

    logic [FLAG_COUNT-1:0] cond;
    logic [FLAG_COUNT-1:0] flag_q;

    assign cond[FLAG_PFULL]  = (occupancy >= CW'(PF_LEVEL));
    assign cond[FLAG_PEMPTY] = (occupancy <= CW'(PE_LEVEL));

    generate
        for (genvar b = 0; b < FLAG_COUNT; b++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_q[b] <= 1'b0;
                end else if (clr && clr_mask[b]) begin
                    flag_q[b] <= 1'b0;
                end else begin
                    flag_q[b] <= flag_q[b] | cond[b];
                end
            end
        end
    endgenerate

    assign flags = flag_q;

    // R8: full flag holds until cleared
    a_r8_pf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLAG_PFULL] && !(clr && clr_mask[FLAG_PFULL])) |=> flags[FLAG_PFULL]);

    // R9: low occupancy raises the empty flag
    a_r9_pe_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((occupancy <= CW'(PE_LEVEL)) && !(clr && clr_mask[FLAG_PEMPTY])) |=> flags[FLAG_PEMPTY]);

    // R10: a masked clear wins at its edge
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && clr_mask[FLAG_PEMPTY]) |=> !flags[FLAG_PEMPTY]);

endmodule

// File: rtl/pkt_fifo.sv
module pkt_fifo
    import pktf_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 512,
    parameter int CUT_THROUGH = 0,
    parameter int START_LEVEL = 16,
    parameter int PF_LEVEL    = 507,
    parameter int PE_LEVEL    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [DATA_W-1:0]     in_data,
    input  logic                  in_last,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [DATA_W-1:0]     out_data,
    output logic                  out_last,
    input  logic                  stat_clr,
    input  logic [FLAG_COUNT-1:0] stat_clr_mask,
    output logic [FLAG_COUNT-1:0] stat_flags
);

    localparam int CW = $clog2(DEPTH) + 1;

    logic          full;
    logic          empty;
    logic [CW-1:0] occupancy;
    logic          wr_fire;
    logic          rd_fire;

    assign in_ready = !full;
    assign wr_fire  = in_valid && !full;
    assign rd_fire  = out_valid && out_ready;

    pktf_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_fire),
        .wr_data   (in_data),
        .wr_last   (in_last),
        .rd_en     (rd_fire),
        .rd_data   (out_data),
        .rd_last   (out_last),
        .occupancy (occupancy),
        .full      (full),
        .empty     (empty)
    );

    pktf_release #(
        .CUT_THROUGH (CUT_THROUGH),
        .START_LEVEL (START_LEVEL),
        .CW          (CW)
    ) u_release (
        .clk          (clk),
        .rst_n        (rst_n),
        .occupancy    (occupancy),
        .empty        (empty),
        .wr_last_fire (wr_fire && in_last),
        .rd_fire      (rd_fire),
        .rd_last      (out_last),
        .out_valid    (out_valid)
    );

    pktf_flags #(
        .CW       (CW),
        .PF_LEVEL (PF_LEVEL),
        .PE_LEVEL (PE_LEVEL)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .occupancy (occupancy),
        .clr       (stat_clr),
        .clr_mask  (stat_clr_mask),
        .flags     (stat_flags)
    );

    // R11: nothing offered while in reset
    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

// File: tb/pkt_fifo_tb.sv
module pkt_fifo_tb;

    localparam int DEPTH = 512;
    localparam int PF    = 507;
    localparam int PE    = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       rdy_a = 1'b0;
    logic       rdy_b = 1'b0;
    logic       clr = 1'b0;
    logic [1:0] mask = '0;

    logic       in_ready_a, out_valid_a, out_last_a;
    logic       in_ready_b, out_valid_b, out_last_b;
    logic [7:0] out_data_a, out_data_b;
    logic [1:0] stat_a, stat_b;

    int  tests = 0;
    int  fails = 0;
    int  occ_a = 0;
    logic [1:0] stat_exp = '0;
    bit  model_on = 0;

    always #4 clk = ~clk;

    pkt_fifo #(.DATA_W(8), .DEPTH(DEPTH), .CUT_THROUGH(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_a),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid_a),
        .out_ready(rdy_a), .out_data(out_data_a), .out_last(out_last_a),
        .stat_clr(clr), .stat_clr_mask(mask), .stat_flags(stat_a));

    pkt_fifo #(.DATA_W(8), .DEPTH(DEPTH), .CUT_THROUGH(1), .START_LEVEL(4)) u_dut_ct (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_b),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid_b),
        .out_ready(rdy_b), .out_data(out_data_b), .out_last(out_last_b),
        .stat_clr(1'b0), .stat_clr_mask(2'b00), .stat_flags(stat_b));

    task automatic check(input bit ok, input string req, input int got, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic tick();
        bit wf, rf, cpf, cpe;
        #3;
        wf  = in_valid && in_ready_a;
        rf  = rdy_a && out_valid_a;
        cpf = (occ_a >= PF);
        cpe = (occ_a <= PE);
        @(posedge clk);
        #2;
        if (model_on) begin
            stat_exp[0] = (clr && mask[0]) ? 1'b0 : (stat_exp[0] | cpf);
            stat_exp[1] = (clr && mask[1]) ? 1'b0 : (stat_exp[1] | cpe);
            occ_a = occ_a + int'(wf) - int'(rf);
            check(stat_a[0] == stat_exp[0], "R8", stat_a[0], stat_exp[0]);
            check(stat_a[1] == stat_exp[1], "R9", stat_a[1], stat_exp[1]);
            check(in_ready_a == (occ_a != DEPTH), "R1", in_ready_a, occ_a != DEPTH);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic l);
        in_valid = 1'b1; in_data = d; in_last = l;
        tick();
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic pop_a(input logic [7:0] d, input logic l);
        check(out_valid_a == 1'b1, "R4", out_valid_a, 1);
        check(out_data_a == d, "R2", out_data_a, d);
        check(out_last_a == l, "R2", out_last_a, l);
        rdy_a = 1'b1;
        tick();
        rdy_a = 1'b0;
    endtask

    task automatic pop_b(input logic [7:0] d, input logic l);
        check(out_valid_b == 1'b1, "R5", out_valid_b, 1);
        check(out_data_b == d, "R2", out_data_b, d);
        check(out_last_b == l, "R2", out_last_b, l);
        rdy_b = 1'b1;
        tick();
        rdy_b = 1'b0;
    endtask

    task automatic clear(input logic [1:0] m);
        clr = 1'b1; mask = m;
        tick();
        clr = 1'b0; mask = '0;
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        tests++;
        $display("FAIL watchdog R2 got hang expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R11: reset state
        check(out_valid_a == 1'b0, "R11", out_valid_a, 0);
        check(out_valid_b == 1'b0, "R11", out_valid_b, 0);
        check(in_ready_a == 1'b1, "R11", in_ready_a, 1);
        check(stat_a == 2'b00, "R11", stat_a, 0);
        rst_n = 1'b1;
        model_on = 1;
        tick();
        check(stat_a[1] == 1'b1, "R9", stat_a[1], 1);

        // R10: clear while condition holds, it returns next edge; bit 0 untouched
        clear(2'b10);
        check(stat_a[1] == 1'b0, "R10", stat_a[1], 0);
        check(stat_a[0] == 1'b0, "R10", stat_a[0], 0);
        tick();
        check(stat_a[1] == 1'b1, "R10", stat_a[1], 1);

        // Long packet: 511 beats, last on the final one
        for (int i = 0; i < 511; i++) begin
            push(8'(i), i == 510);
            if (i < 510) check(out_valid_a == 1'b0, "R3", out_valid_a, 0);
            if (i == 2)  check(out_valid_b == 1'b0, "R5", out_valid_b, 0);
            if (i == 3)  check(out_valid_b == 1'b1, "R5", out_valid_b, 1);
            if (i == 100) begin
                clear(2'b10);
                check(stat_a[1] == 1'b0, "R10", stat_a[1], 0);
            end
            if (i == 506) check(stat_a[0] == 1'b0, "R8", stat_a[0], 0);
            if (i == 507) check(stat_a[0] == 1'b1, "R8", stat_a[0], 1);
        end
        check(out_valid_a == 1'b1, "R3", out_valid_a, 1);
        check(stat_a[1] == 1'b0, "R10", stat_a[1], 0);

        // R7: write and read at the same edge
        in_valid = 1'b1; in_data = 8'hAA; in_last = 1'b1; rdy_a = 1'b1;
        check(out_data_a == 8'h00, "R2", out_data_a, 0);
        tick();
        in_valid = 1'b0; in_last = 1'b0; rdy_a = 1'b0;
        check(in_ready_a == 1'b1, "R7", in_ready_a, 1);
        check(in_ready_b == 1'b0, "R1", in_ready_b, 0);
        push(8'hBB, 1'b1);
        check(in_ready_a == 1'b0, "R1", in_ready_a, 0);
        push(8'hCC, 1'b1);

        // R10: clear full flag at full occupancy
        clear(2'b01);
        check(stat_a[0] == 1'b0, "R10", stat_a[0], 0);
        tick();
        check(stat_a[0] == 1'b1, "R10", stat_a[0], 1);

        for (int i = 1; i < 511; i++) pop_a(8'(i), i == 510);
        pop_a(8'hAA, 1'b1);
        pop_a(8'hBB, 1'b1);
        check(out_valid_a == 1'b0, "R1", out_valid_a, 0);

        for (int i = 0; i < 511; i++) pop_b(8'(i), i == 510);
        pop_b(8'hAA, 1'b1);
        check(out_valid_b == 1'b0, "R1", out_valid_b, 0);

        // Five-beat packet: cut-through starts at level 4
        for (int i = 0; i < 5; i++) begin
            push(8'(10 + i), i == 4);
            check(out_valid_b == (i >= 3), "R5", out_valid_b, i >= 3);
            check(out_valid_a == (i == 4), "R3", out_valid_a, i == 4);
        end
        for (int i = 0; i < 5; i++) pop_b(8'(10 + i), i == 4);
        for (int i = 0; i < 5; i++) pop_a(8'(10 + i), i == 4);
        check(out_valid_a == 1'b0, "R4", out_valid_a, 0);

        // Short packet below the start level
        push(8'd20, 1'b0);
        check(out_valid_b == 1'b0, "R6", out_valid_b, 0);
        push(8'd21, 1'b1);
        check(out_valid_b == 1'b1, "R6", out_valid_b, 1);
        pop_b(8'd20, 1'b0);
        pop_b(8'd21, 1'b1);
        check(out_valid_b == 1'b0, "R6", out_valid_b, 0);
        pop_a(8'd20, 1'b0);
        pop_a(8'd21, 1'b1);
        tick();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule